// File: doc/BRIEF.md
# Banked Parallel Table Lookup

This block is a fixed-latency store of small constant tables. It is organised as banks. Each bank has eight tables, and each table has 256 rows of 32-bit words. Each table has two read ports, so one request returns sixteen words. A 128-bit index operand supplies sixteen row numbers, one per byte. A bank field picks which set of eight tables answers. The sixteen words come back together on a 512-bit result one clock later. That latency does not depend on the index values, and there is no miss path.

Software fills the tables through an initialisation port. Each write carries a bank number, a row number and eight 32-bit words, one word per table of that bank. A full bank therefore loads in 256 writes. A write takes its cycle to itself. While it is pending, the read side signals not-ready, and any read offered in that cycle is not accepted.

Top module: `banked_lut`

## Requirements
- R1: While reset is asserted and after it is released, with no read accepted, `rsp_valid` is 0 and `rsp_data` is all zeros.
- R2: Result word k (k = 0..15) sits at `rsp_data[32k+31:32k]`. It is the entry of table (k mod 8) at the row given by index byte k, `rd_index[8k+7:8k]`. Words 0..7 therefore come from the first ports, which are fed by the low eight bytes. Words 8..15 come from the second ports, which are fed by the high eight bytes.
- R3: `rd_bank` selects which bank's eight tables supply all sixteen words. The other banks do not influence the result.
- R4: A read is accepted when `rd_valid` and `rd_ready` are both high. Every accepted read raises `rsp_valid` on the following clock, whatever the index values. Reads on consecutive cycles produce results on consecutive cycles.
- R5: A write with `wr_en` high stores `wr_data[32t+31:32t]` into table t, row `wr_row`, of bank `wr_bank`, for all eight t at once. A read accepted in the next cycle returns the new words.
- R6: In a cycle with `wr_en` high, `rd_ready` is low and a read offered in that cycle is not accepted. No `rsp_valid` follows from it.
- R7: In any cycle after which no read was accepted, `rsp_valid` is 0 and `rsp_data` keeps its previous value.
- R8: A read naming a bank number at or above `NUM_BANKS` (default 2) is accepted and returns all zeros. A write naming such a bank changes no stored entry.
- R9: `rd_ready` is high in every cycle where `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read can be accepted this cycle |
| rd_index | input | 128 | Sixteen row indices, one per byte |
| rd_bank | input | 2 | Bank selected for the read |
| rsp_valid | output | 1 | Result valid, one clock after acceptance |
| rsp_data | output | 512 | Sixteen 32-bit result words |
| wr_en | input | 1 | Initialisation write strobe |
| wr_bank | input | 2 | Bank written |
| wr_row | input | 8 | Row written in all eight tables |
| wr_data | input | 256 | Eight 32-bit words, word t for table t |

## Verification
Both banks are loaded with words that encode bank, table and row. Any wrong bank, table, port or row then shows up as a distinct value. Reads are tried with a set of index patterns:
- all-zero and all-ones indices, which expose a stuck address;
- ascending and descending byte runs, which catch lanes that are swapped or mirrored;
- a row-shift permutation;
- patterns whose low and high halves differ, which separate the first read port from the second.

Directed cases cover a write landing in the same cycle as a read, an overwrite read back in the next cycle, back-to-back reads, idle hold, and reads and writes that name a bank that does not exist.

// File: rtl/blut_pkg.sv
package blut_pkg;
    localparam int BLUT_TABLES  = 8;
    localparam int BLUT_WORD_W  = 32;
    localparam int BLUT_ROW_W   = 8;
    localparam int BLUT_BANKS   = 2;
    localparam int BLUT_BANK_W  = 2;
    localparam int BLUT_PORTS   = 2;
endpackage

// File: rtl/lut_table.sv
module lut_table #(
    parameter int WORD_W = 32,
    parameter int ROW_W  = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ROW_W-1:0]  raddr_a,
    input  logic [ROW_W-1:0]  raddr_b,
    output logic [WORD_W-1:0] rdata_a,
    output logic [WORD_W-1:0] rdata_b
);
    localparam int ENTRIES = 1 << ROW_W;

    logic [WORD_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
    parameter int TABLES = 8,
    parameter int WORD_W = 32,
    parameter int ROW_W  = 8
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [ROW_W-1:0]           wrow,
    input  logic [TABLES*WORD_W-1:0]   wdata,
    input  logic [TABLES*ROW_W-1:0]    idx_lo,
    input  logic [TABLES*ROW_W-1:0]    idx_hi,
    output logic [2*TABLES*WORD_W-1:0] rdata
);
    localparam int HALF_W = TABLES * WORD_W;

    logic [HALF_W-1:0] rd_lo;
    logic [HALF_W-1:0] rd_hi;

    for (genvar t = 0; t < TABLES; t++) begin : g_tbl
        lut_table #(
            .WORD_W (WORD_W),
            .ROW_W  (ROW_W)
        ) u_tbl (
            .clk     (clk),
            .we      (we),
            .waddr   (wrow),
            .wdata   (wdata[t*WORD_W +: WORD_W]),
            .raddr_a (idx_lo[t*ROW_W +: ROW_W]),
            .raddr_b (idx_hi[t*ROW_W +: ROW_W]),
            .rdata_a (rd_lo[t*WORD_W +: WORD_W]),
            .rdata_b (rd_hi[t*WORD_W +: WORD_W])
        );
    end

    // first ports fill the low half of the lanes, second ports the high half
    assign rdata = {rd_hi, rd_lo};
endmodule

// File: rtl/banked_lut.sv
module banked_lut
    import blut_pkg::*;
#(
    parameter int NUM_BANKS = BLUT_BANKS,
    parameter int BANK_W    = BLUT_BANK_W,
    parameter int TABLES    = BLUT_TABLES,
    parameter int WORD_W    = BLUT_WORD_W,
    parameter int ROW_W     = BLUT_ROW_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  rd_valid,
    output logic                                  rd_ready,
    input  logic [BLUT_PORTS*TABLES*ROW_W-1:0]    rd_index,
    input  logic [BANK_W-1:0]                     rd_bank,
    output logic                                  rsp_valid,
    output logic [BLUT_PORTS*TABLES*WORD_W-1:0]   rsp_data,
    input  logic                                  wr_en,
    input  logic [BANK_W-1:0]                     wr_bank,
    input  logic [ROW_W-1:0]                      wr_row,
    input  logic [TABLES*WORD_W-1:0]              wr_data
);
    localparam int LANES = BLUT_PORTS * TABLES;
    localparam int OUT_W = LANES * WORD_W;
    localparam int HIX_W = TABLES * ROW_W;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] data;
    } rsp_state_t;

    rsp_state_t st_d, st_q;

    logic [OUT_W-1:0] bank_rd [NUM_BANKS];
    logic [OUT_W-1:0] sel_rd;
    logic             accept;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        lut_bank #(
            .TABLES (TABLES),
            .WORD_W (WORD_W),
            .ROW_W  (ROW_W)
        ) u_bank (
            .clk    (clk),
            .we     (wr_en && (wr_bank == BANK_W'(b))),
            .wrow   (wr_row),
            .wdata  (wr_data),
            .idx_lo (rd_index[HIX_W-1:0]),
            .idx_hi (rd_index[2*HIX_W-1:HIX_W]),
            .rdata  (bank_rd[b])
        );
    end

    // bank numbers with no bank behind them select nothing and yield zero
    always_comb begin
        sel_rd = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_bank == BANK_W'(b)) begin
                sel_rd = bank_rd[b];
            end
        end
    end

    assign rd_ready = !wr_en;
    assign accept   = rd_valid && rd_ready;

    always_comb begin
        st_d     = st_q;
        st_d.vld = accept;
        if (accept) begin
            st_d.data = sel_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.vld;
    assign rsp_data  = st_q.data;
endmodule

// File: rtl/banked_lut_chk.sv
module banked_lut_chk #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 2,
    parameter int OUT_W     = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [BANK_W-1:0] rd_bank,
    input logic              wr_en,
    input logic              rsp_valid,
    input logic [OUT_W-1:0]  rsp_data
);
    p_fixed_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> rsp_valid);

    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_ready) |=> !rsp_valid);

    p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_ready) |=> $stable(rsp_data));

    p_write_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_valid) |=> !rsp_valid);

    p_missing_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && (int'(rd_bank) >= NUM_BANKS)) |=> (rsp_data == '0));
endmodule

bind banked_lut banked_lut_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .OUT_W     (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_bank   (rd_bank),
    .wr_en     (wr_en),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/banked_lut_tb.sv
module banked_lut_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         rd_valid;
    logic         rd_ready;
    logic [127:0] rd_index;
    logic [1:0]   rd_bank;
    logic         rsp_valid;
    logic [511:0] rsp_data;
    logic         wr_en;
    logic [1:0]   wr_bank;
    logic [7:0]   wr_row;
    logic [255:0] wr_data;

    int checks = 0;
    int errors = 0;

    // single overwritten row tracked by the model
    bit         ovr_on = 1'b0;
    logic [1:0] ovr_bank;
    logic [7:0] ovr_row;

    always #5 clk = ~clk;

    banked_lut u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .rd_index  (rd_index),
        .rd_bank   (rd_bank),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_row    (wr_row),
        .wr_data   (wr_data)
    );

    function automatic logic [31:0] fill_word(input int b, input int t, input logic [7:0] r);
        return {4'hB, 4'(b), 4'h0, 4'(t), r, r ^ 8'h5A};
    endfunction

    function automatic logic [31:0] ovr_word(input int t);
        return 32'hD00D_0000 | 32'(t * 16'h0111);
    endfunction

    function automatic logic [31:0] exp_word(input int b, input int t, input logic [7:0] r);
        if (b >= 2) return 32'h0;
        if (ovr_on && b == int'(ovr_bank) && r == ovr_row) return ovr_word(t);
        return fill_word(b, t, r);
    endfunction

    function automatic logic [511:0] exp_resp(input logic [1:0] b, input logic [127:0] idx);
        logic [511:0] v;
        for (int k = 0; k < 16; k++) begin
            v[32*k +: 32] = exp_word(int'(b), k % 8, idx[8*k +: 8]);
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [511:0] act,
                         input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [1:0] b, input logic [127:0] idx, input string req);
        @(negedge clk);
        rd_valid = 1'b1; rd_bank = b; rd_index = idx;
        @(negedge clk);
        rd_valid = 1'b0;
        check(rsp_valid === 1'b1, {req, " valid"}, 512'(rsp_valid), 512'd1);
        check(rsp_data === exp_resp(b, idx), {req, " data"}, rsp_data, exp_resp(b, idx));
    endtask

    // {bank, index}
    localparam logic [129:0] VEC [8] = '{
        {2'd0, 128'h0},
        {2'd0, {16{8'hFF}}},
        {2'd0, 128'h0F0E0D0C_0B0A0908_07060504_03020100},
        {2'd1, 128'h00010203_04050607_08090A0B_0C0D0E0F},
        {2'd1, 128'h040E0904_0D03080E_03070C02_0B06010C},
        {2'd0, 128'hAAAAAAAA_AAAAAAAA_55555555_55555555},
        {2'd1, 128'h10203040_50607080_8F7F6F5F_4F3F2F1F},
        {2'd0, 128'hC3A51E77_9B2D40E8_F1062B99_7D38C4E0}
    };

    initial begin
        rst_n = 1'b0; rd_valid = 1'b0; rd_index = '0; rd_bank = '0;
        wr_en = 1'b0; wr_bank = '0; wr_row = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rsp_valid === 1'b0, "R1 valid in reset", 512'(rsp_valid), 512'd0);
        check(rsp_data === '0, "R1 data in reset", rsp_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_data === '0, "R1 after release", rsp_data, '0);
        // R9: ready when idle
        check(rd_ready === 1'b1, "R9 ready idle", 512'(rd_ready), 512'd1);

        // R5: load both banks, one row per cycle
        for (int b = 0; b < 2; b++) begin
            for (int r = 0; r < 256; r++) begin
                wr_en = 1'b1; wr_bank = 2'(b); wr_row = 8'(r);
                for (int t = 0; t < 8; t++) wr_data[32*t +: 32] = fill_word(b, t, 8'(r));
                @(negedge clk);
            end
        end
        wr_en = 1'b0;

        // R2, R3, R4: table walk
        for (int i = 0; i < 8; i++) begin
            do_read(VEC[i][129:128], VEC[i][127:0], "R2 R3 R4 vector");
        end

        // R7: idle cycles keep data, no valid
        begin
            logic [511:0] held;
            held = rsp_data;
            repeat (3) @(negedge clk);
            check(rsp_valid === 1'b0, "R7 idle valid", 512'(rsp_valid), 512'd0);
            check(rsp_data === held, "R7 idle hold", rsp_data, held);
        end

        // R6, R9: write and read in the same cycle
        begin
            logic [511:0] held;
            held = rsp_data;
            @(negedge clk);
            wr_en = 1'b1; wr_bank = 2'd0; wr_row = 8'h44;
            for (int t = 0; t < 8; t++) wr_data[32*t +: 32] = fill_word(0, t, 8'h44);
            rd_valid = 1'b1; rd_bank = 2'd1; rd_index = {16{8'h44}};
            #1;
            check(rd_ready === 1'b0, "R6 ready low on write", 512'(rd_ready), 512'd0);
            @(negedge clk);
            wr_en = 1'b0; rd_valid = 1'b0;
            check(rsp_valid === 1'b0, "R6 stalled read no valid", 512'(rsp_valid), 512'd0);
            check(rsp_data === held, "R6 stalled read data held", rsp_data, held);
            #1;
            check(rd_ready === 1'b1, "R9 ready after write", 512'(rd_ready), 512'd1);
        end

        // R5: overwrite then read on the next cycle
        @(negedge clk);
        wr_en = 1'b1; wr_bank = 2'd1; wr_row = 8'h33;
        for (int t = 0; t < 8; t++) wr_data[32*t +: 32] = ovr_word(t);
        ovr_on = 1'b1; ovr_bank = 2'd1; ovr_row = 8'h33;
        @(negedge clk);
        wr_en = 1'b0;
        rd_valid = 1'b1; rd_bank = 2'd1; rd_index = {16{8'h33}};
        @(negedge clk);
        rd_valid = 1'b0;
        check(rsp_data === exp_resp(2'd1, {16{8'h33}}), "R5 overwrite visible", rsp_data,
              exp_resp(2'd1, {16{8'h33}}));
        // R3: other bank untouched
        do_read(2'd0, {16{8'h33}}, "R3 other bank unchanged");

        // R4: back-to-back reads
        @(negedge clk);
        rd_valid = 1'b1; rd_bank = 2'd0; rd_index = VEC[2][127:0];
        @(negedge clk);
        check(rsp_data === exp_resp(2'd0, VEC[2][127:0]), "R4 first of pair", rsp_data,
              exp_resp(2'd0, VEC[2][127:0]));
        rd_bank = 2'd1; rd_index = VEC[3][127:0];
        @(negedge clk);
        rd_valid = 1'b0;
        check(rsp_valid === 1'b1, "R4 second valid", 512'(rsp_valid), 512'd1);
        check(rsp_data === exp_resp(2'd1, VEC[3][127:0]), "R4 second of pair", rsp_data,
              exp_resp(2'd1, VEC[3][127:0]));

        // R8: missing bank reads zero
        do_read(2'd2, VEC[2][127:0], "R8 missing bank read");
        do_read(2'd3, {16{8'hFF}}, "R8 missing bank 3 read");

        // R8: write to missing bank changes nothing
        @(negedge clk);
        wr_en = 1'b1; wr_bank = 2'd3; wr_row = 8'h10; wr_data = {8{32'hFFFF_FFFF}};
        @(negedge clk);
        wr_en = 1'b0;
        do_read(2'd0, {16{8'h10}}, "R8 missing bank write bank0");
        do_read(2'd1, {16{8'h10}}, "R8 missing bank write bank1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule